// File: doc/BRIEF.md
# Sprite-Table and Video-Memory DMA Controller

This block holds two byte-wide copy engines that share one master port on an 8-bit CPU bus with 16-bit addresses. The object engine copies a fixed table of 160 bytes from a page-aligned source into the sprite attribute area at 0xFE00. A single write of the source page starts it. While it runs, it tells the CPU side which addresses the CPU must not touch. The video engine copies a block of 16-byte units from a programmable source into video memory. It is set up through four pointer registers and started through a control register. When it finishes, it writes its final pointers and a done flag back into those registers.

Each byte moves in two bus cycles: a read cycle, with `bus_re` high and the source address driven, then on the next clock a write cycle, with `bus_we` high and the destination address and captured byte driven. Pacing counts `tick` pulses, so the engines slow down with the system cycle rate. The object engine always wins the bus. The video engine freezes while the object engine is busy and resumes afterwards without losing place.

Top module: `gfx_dma_ctrl`

## Requirements
- R1: After reset, `bus_re`, `bus_we` and `cpu_block` are low. Registers 1 to 4 read 0x00, register 5 reads 0xFF and register 0 reads 0x00.
- R2: A write to register 0 with a page value of 0xF1 or below starts an object copy from page×0x100. A page above 0xF1 is ignored and leaves register 0 and the bus unchanged.
- R3: The first object read comes on the 8th tick after the start write. Each later read comes 4 ticks after the previous one, for 160 reads in all. Cycles without a tick do not count. Each read is followed on the next clock by a write of that byte to 0xFE00 plus the offsets 0x00 to 0x9F in order. A new start restarts the copy.
- R4: While the object engine is active, from its start until its last write, `cpu_block` is high for every `cpu_addr` in 0xFE00–0xFEFF. When it is idle, `cpu_block` is low.
- R5: With `model_color`=0, `cpu_block` is also high in 0x8000–0x9FFF when source page bits [7:5] equal 4, and in 0xA000–0xFDFF for any other value.
- R6: With `model_color`=1, the extra blocked window is 0x8000–0x9FFF for index 4, 0xC000–0xFDFF for index 6, and 0xA000–0xBFFF for every other index.
- R7: The video source is {reg1,reg2} with bits [3:0] cleared. The destination is ({reg3,reg4} AND 0x1FF0) OR 0x8000. A control write whose source lies in 0x8000–0x9FFF starts nothing and changes no register.
- R8: A write to register 5 with bit 7 clear starts a copy of ((value AND 0x7F)+1)×16 bytes. The first read comes on the next tick and each later read 2 ticks after the previous one. A write with bit 7 set is stored and starts nothing.
- R9: On the clock of the last video write, registers 1 to 4 take the final source and destination pointers (start plus length) and bit 7 of register 5 is set.
- R10: The video engine issues no read while the object engine is active, and it resumes with its remaining count intact.
- R11: `reg_rdata` returns register `reg_sel`: 0 for the accepted object page, 1 to 4 for the source high/low and destination high/low bytes, 5 for control, and 0xFF for codes 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | System cycle enable for pacing |
| model_color | input | 1 | Selects the colour-model conflict table |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register code |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_sel` |
| cpu_addr | input | 16 | Address the CPU wants to access |
| cpu_block | output | 1 | CPU access to `cpu_addr` must be suppressed |
| bus_rdata | input | 8 | Read data for the address on `bus_addr` |
| bus_addr | output | 16 | Master address |
| bus_wdata | output | 8 | Master write data |
| bus_we | output | 1 | Master write strobe |
| bus_re | output | 1 | Master read strobe |

## Verification
Assertions check on every cycle that the two engines never drive the port together and that the video engine issues no read while stalled. They also check that an object read is always followed by a write into the attribute page and that the attribute page is blocked whenever the object engine is active. Finally, they check that an accepted page never exceeds the limit and that the done flag is set when the video engine goes idle. Only the bench's scenarios can show the tick-exact pacing, the byte order and values, the write-back pointer values, the per-model conflict windows, and that ignored or rejected writes leave the registers and bus untouched. The bench does this by comparing every cycle against its reference model.

// File: rtl/gfx_dma_pkg.sv
package gfx_dma_pkg;

    localparam int AW = 16;
    localparam int DW = 8;

    typedef logic [AW-1:0] addr_t;
    typedef logic [DW-1:0] byte_t;

    typedef enum logic [2:0] {
        SEL_OBJ_PAGE = 3'd0,
        SEL_SRC_HI   = 3'd1,
        SEL_SRC_LO   = 3'd2,
        SEL_DST_HI   = 3'd3,
        SEL_DST_LO   = 3'd4,
        SEL_CTRL     = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic  rd;
        logic  wr;
        addr_t addr;
        byte_t data;
    } bus_req_t;

    localparam bus_req_t BUS_IDLE = '{rd: 1'b0, wr: 1'b0, addr: '0, data: '0};

    typedef struct packed {
        byte_t src_hi;
        byte_t src_lo;
        byte_t dst_hi;
        byte_t dst_lo;
        byte_t ctrl;
    } vid_regs_t;

    // Half-open window [lo, hi)
    typedef struct packed {
        addr_t lo;
        addr_t hi;
    } window_t;

    function automatic window_t conflict_window(logic [2:0] idx, logic color);
        window_t w;
        if (idx == 3'd4) begin
            w.lo = 16'h8000; w.hi = 16'hA000;
        end else if (!color) begin
            w.lo = 16'hA000; w.hi = 16'hFE00;
        end else if (idx == 3'd6) begin
            w.lo = 16'hC000; w.hi = 16'hFE00;
        end else begin
            w.lo = 16'hA000; w.hi = 16'hC000;
        end
        return w;
    endfunction

    function automatic logic in_window(addr_t a, window_t w);
        return (a >= w.lo) && (a < w.hi);
    endfunction

endpackage

// File: rtl/obj_dma_engine.sv
module obj_dma_engine
    import gfx_dma_pkg::*;
#(
    parameter int   LEN      = 160,
    parameter int   FIRST    = 8,
    parameter int   GAP      = 4,
    parameter byte_t MAX_PAGE = 8'hF1,
    parameter byte_t DST_PAGE = 8'hFE
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     start,
    input  byte_t    page,
    input  byte_t    rdata,
    output bus_req_t req,
    output logic     active,
    output byte_t    src_page
);
    localparam int CW   = $clog2(LEN + 1);
    localparam int WMAX = (FIRST > GAP) ? FIRST : GAP;
    localparam int WW   = $clog2(WMAX + 1);

    logic [CW-1:0] rem_q;
    logic [WW-1:0] wait_q;
    addr_t         src_q;
    byte_t         off_q;
    logic          pend_q;
    byte_t         wdat_q;
    addr_t         waddr_q;
    logic          rd;
    logic          start_ok;

    assign start_ok = start && (page <= MAX_PAGE);
    assign rd       = (rem_q != '0) && tick && (wait_q == WW'(1));
    assign active   = (rem_q != '0) || pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q    <= '0;
            wait_q   <= '0;
            src_q    <= '0;
            off_q    <= '0;
            pend_q   <= 1'b0;
            wdat_q   <= '0;
            waddr_q  <= '0;
            src_page <= '0;
        end else begin
            pend_q <= 1'b0;
            if (rd) begin
                pend_q  <= 1'b1;
                wdat_q  <= rdata;
                waddr_q <= {DST_PAGE, off_q};
                src_q   <= src_q + 16'd1;
                off_q   <= off_q + 8'd1;
                rem_q   <= rem_q - CW'(1);
                wait_q  <= WW'(GAP);
            end else if (tick && (rem_q != '0)) begin
                wait_q <= wait_q - WW'(1);
            end
            if (start_ok) begin
                src_q    <= {page, 8'h00};
                src_page <= page;
                off_q    <= '0;
                rem_q    <= CW'(LEN);
                wait_q   <= WW'(FIRST);
            end
        end
    end

    always_comb begin
        req = BUS_IDLE;
        if (pend_q) begin
            req.wr   = 1'b1;
            req.addr = waddr_q;
            req.data = wdat_q;
        end else if (rd) begin
            req.rd   = 1'b1;
            req.addr = src_q;
        end
    end

    // R3: every read is followed by a write into the attribute page
    a_r3_write_after_read: assert property (@(posedge clk) disable iff (rst)
        rd |=> (req.wr && req.addr[15:8] == DST_PAGE));

    // R2: an accepted page never exceeds the limit
    a_r2_page_limit: assert property (@(posedge clk) disable iff (rst)
        active |-> (src_page <= MAX_PAGE));

    // R3: the pacing counter stays within its reload range
    a_r3_wait_range: assert property (@(posedge clk) disable iff (rst)
        wait_q <= WW'(WMAX));

endmodule

// File: rtl/vid_dma_engine.sv
module vid_dma_engine
    import gfx_dma_pkg::*;
#(
    parameter int UNIT  = 16,
    parameter int GAP   = 2,
    parameter int CNT_W = 7
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      hold,
    input  logic      reg_we,
    input  logic [2:0] reg_sel,
    input  byte_t     reg_wdata,
    input  byte_t     rdata,
    output bus_req_t  req,
    output logic      active,
    output vid_regs_t regs
);
    localparam int MAXLEN = (1 << CNT_W) * UNIT;
    localparam int LW     = $clog2(MAXLEN + 1);
    localparam int VW     = $clog2(GAP + 1);

    logic [LW-1:0] rem_q;
    logic [VW-1:0] wait_q;
    addr_t         src_q;
    addr_t         dst_q;
    logic          pend_q;
    byte_t         wdat_q;
    addr_t         waddr_q;
    logic          rd;
    logic          ctrl_wr;
    logic          bad_src;
    logic          go;
    addr_t         src_calc;
    addr_t         dst_calc;
    logic [LW-1:0] len_calc;

    assign src_calc = {regs.src_hi, regs.src_lo} & 16'hFFF0;
    assign dst_calc = ({regs.dst_hi, regs.dst_lo} & 16'h1FF0) | 16'h8000;
    assign bad_src  = (src_calc[15:13] == 3'b100);
    assign len_calc = (LW'(reg_wdata[CNT_W-1:0]) + LW'(1)) * LW'(UNIT);
    assign ctrl_wr  = reg_we && (reg_sel_e'(reg_sel) == SEL_CTRL);
    assign go       = ctrl_wr && !reg_wdata[7] && !bad_src;
    assign rd       = (rem_q != '0) && tick && !hold && (wait_q == VW'(1));
    assign active   = (rem_q != '0) || pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q   <= '0;
            wait_q  <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            pend_q  <= 1'b0;
            wdat_q  <= '0;
            waddr_q <= '0;
            regs    <= '{src_hi: 8'h00, src_lo: 8'h00, dst_hi: 8'h00,
                         dst_lo: 8'h00, ctrl: 8'hFF};
        end else begin
            pend_q <= 1'b0;
            if (rd) begin
                pend_q  <= 1'b1;
                wdat_q  <= rdata;
                waddr_q <= dst_q;
                src_q   <= src_q + 16'd1;
                dst_q   <= dst_q + 16'd1;
                rem_q   <= rem_q - LW'(1);
                wait_q  <= VW'(GAP);
            end else if (tick && !hold && (rem_q != '0)) begin
                wait_q <= wait_q - VW'(1);
            end
            if (pend_q && (rem_q == '0)) begin
                regs.src_hi <= src_q[15:8];
                regs.src_lo <= src_q[7:0];
                regs.dst_hi <= dst_q[15:8];
                regs.dst_lo <= dst_q[7:0];
                regs.ctrl   <= regs.ctrl | 8'h80;
            end
            if (reg_we) begin
                case (reg_sel_e'(reg_sel))
                    SEL_SRC_HI: regs.src_hi <= reg_wdata;
                    SEL_SRC_LO: regs.src_lo <= reg_wdata;
                    SEL_DST_HI: regs.dst_hi <= reg_wdata;
                    SEL_DST_LO: regs.dst_lo <= reg_wdata;
                    SEL_CTRL:   if (reg_wdata[7] || !bad_src) regs.ctrl <= reg_wdata;
                    default: ;
                endcase
            end
            if (go) begin
                src_q  <= src_calc;
                dst_q  <= dst_calc;
                rem_q  <= len_calc;
                wait_q <= VW'(1);
            end
        end
    end

    always_comb begin
        req = BUS_IDLE;
        if (pend_q) begin
            req.wr   = 1'b1;
            req.addr = waddr_q;
            req.data = wdat_q;
        end else if (rd) begin
            req.rd   = 1'b1;
            req.addr = src_q;
        end
    end

    // R8: the remaining count never exceeds the largest programmable length
    a_r8_len_bound: assert property (@(posedge clk) disable iff (rst)
        rem_q <= LW'(MAXLEN));

    // R9: going idle leaves the done flag set
    a_r9_done_flag: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> regs.ctrl[7]);

    // R10: no read is issued while stalled
    a_r10_stall: assert property (@(posedge clk) disable iff (rst)
        hold |-> !req.rd);

endmodule

// File: rtl/cpu_guard.sv
module cpu_guard
    import gfx_dma_pkg::*;
(
    input  logic       obj_active,
    input  logic       color,
    input  logic [2:0] src_idx,
    input  addr_t      cpu_addr,
    output logic       cpu_block
);
    window_t win;
    logic    in_attr;

    assign win       = conflict_window(src_idx, color);
    assign in_attr   = (cpu_addr[15:8] == 8'hFE);
    assign cpu_block = obj_active && (in_attr || in_window(cpu_addr, win));

endmodule

// File: rtl/gfx_dma_ctrl.sv
module gfx_dma_ctrl
    import gfx_dma_pkg::*;
#(
    parameter int OBJ_LEN   = 160,
    parameter int OBJ_FIRST = 8,
    parameter int OBJ_GAP   = 4,
    parameter int VID_UNIT  = 16,
    parameter int VID_GAP   = 2,
    parameter int VID_CNT_W = 7
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        model_color,
    input  logic        reg_we,
    input  logic [2:0]  reg_sel,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic [15:0] cpu_addr,
    output logic        cpu_block,
    input  logic [7:0]  bus_rdata,
    output logic [15:0] bus_addr,
    output logic [7:0]  bus_wdata,
    output logic        bus_we,
    output logic        bus_re
);
    bus_req_t  obj_req;
    bus_req_t  vid_req;
    bus_req_t  sel_req;
    logic      obj_active;
    logic      vid_active;
    byte_t     obj_page;
    vid_regs_t vid_regs;
    logic      obj_start;

    assign obj_start = reg_we && (reg_sel_e'(reg_sel) == SEL_OBJ_PAGE);

    obj_dma_engine #(
        .LEN   (OBJ_LEN),
        .FIRST (OBJ_FIRST),
        .GAP   (OBJ_GAP)
    ) u_obj (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .start    (obj_start),
        .page     (reg_wdata),
        .rdata    (bus_rdata),
        .req      (obj_req),
        .active   (obj_active),
        .src_page (obj_page)
    );

    vid_dma_engine #(
        .UNIT  (VID_UNIT),
        .GAP   (VID_GAP),
        .CNT_W (VID_CNT_W)
    ) u_vid (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .hold      (obj_active),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .rdata     (bus_rdata),
        .req       (vid_req),
        .active    (vid_active),
        .regs      (vid_regs)
    );

    cpu_guard u_guard (
        .obj_active (obj_active),
        .color      (model_color),
        .src_idx    (obj_page[7:5]),
        .cpu_addr   (cpu_addr),
        .cpu_block  (cpu_block)
    );

    // Object engine owns the port whenever it requests it
    assign sel_req   = (obj_req.rd || obj_req.wr) ? obj_req : vid_req;
    assign bus_addr  = sel_req.addr;
    assign bus_wdata = sel_req.data;
    assign bus_we    = sel_req.wr;
    assign bus_re    = sel_req.rd;

    always_comb begin
        case (reg_sel_e'(reg_sel))
            SEL_OBJ_PAGE: reg_rdata = obj_page;
            SEL_SRC_HI:   reg_rdata = vid_regs.src_hi;
            SEL_SRC_LO:   reg_rdata = vid_regs.src_lo;
            SEL_DST_HI:   reg_rdata = vid_regs.dst_hi;
            SEL_DST_LO:   reg_rdata = vid_regs.dst_lo;
            SEL_CTRL:     reg_rdata = vid_regs.ctrl;
            default:      reg_rdata = 8'hFF;
        endcase
    end

    // R10: the two engines never request the port together
    a_r10_single_master: assert property (@(posedge clk) disable iff (rst)
        !((obj_req.rd || obj_req.wr) && (vid_req.rd || vid_req.wr)));

    // R4: attribute page is blocked while the object engine runs
    a_r4_attr_blocked: assert property (@(posedge clk) disable iff (rst)
        (obj_active && cpu_addr[15:8] == 8'hFE) |-> cpu_block);

    // R4: nothing is blocked while the object engine is idle
    a_r4_idle_open: assert property (@(posedge clk) disable iff (rst)
        !obj_active |-> !cpu_block);

    // R10: a video read never overlaps object activity
    a_r10_vid_quiet: assert property (@(posedge clk) disable iff (rst)
        obj_active |-> !vid_req.rd);

endmodule

// File: tb/test_gfx_dma_ctrl.sv
`timescale 1ns/1ps
module test_gfx_dma_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b1;
    logic        model_color = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic [15:0] cpu_addr = 16'd0;
    logic        cpu_block;
    logic [7:0]  bus_rdata;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_we;
    logic        bus_re;

    int checks = 0;
    int fails  = 0;
    bit rand_tick = 1'b0;

    always #2 clk = ~clk;

    function automatic int memf(int a);
        return ((a & 255) ^ ((a >> 8) & 255) ^ 'h5A) & 255;
    endfunction

    assign bus_rdata = 8'(memf(int'(bus_addr)));

    gfx_dma_ctrl i_gfx_dma_ctrl (
        .clk(clk), .rst(rst), .tick(tick), .model_color(model_color),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cpu_addr(cpu_addr), .cpu_block(cpu_block),
        .bus_rdata(bus_rdata), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int s_rem, s_wait, s_src, s_off, s_pend, s_wa, s_wd, s_page;
    int v_rem, v_wait, v_src, v_dst, v_pend, v_wa, v_wd;
    int r [0:5];
    int cyc = 0;
    int wr_cnt = 0, rd_cnt = 0;
    int first_rd_cyc = -1, second_rd_cyc = -1, start_cyc = 0;
    int first_wa = -1, first_wd = -1, last_wa = -1;

    function automatic bit model_block(int a);
        int lo, hi, idx;
        if (!(s_rem > 0 || s_pend)) return 1'b0;
        if ((a >> 8) == 'hFE) return 1'b1;
        idx = (s_page >> 5) & 7;
        if (idx == 4) begin lo = 'h8000; hi = 'hA000; end
        else if (!model_color) begin lo = 'hA000; hi = 'hFE00; end
        else if (idx == 6) begin lo = 'hC000; hi = 'hFE00; end
        else begin lo = 'hA000; hi = 'hC000; end
        return (a >= lo) && (a < hi);
    endfunction

    always @(negedge clk) begin
        if (rand_tick) tick <= ($urandom % 3) != 0;
        else           tick <= 1'b1;
    end

    always @(negedge clk) begin
        #1;
        cyc++;
        if (rst) begin
            s_rem = 0; s_wait = 0; s_src = 0; s_off = 0; s_pend = 0; s_wa = 0; s_wd = 0; s_page = 0;
            v_rem = 0; v_wait = 0; v_src = 0; v_dst = 0; v_pend = 0; v_wa = 0; v_wd = 0;
            r[0] = 0; r[1] = 0; r[2] = 0; r[3] = 0; r[4] = 0; r[5] = 'hFF;
        end else begin
            bit s_act, s_rd, v_rd, e_we, e_re, e_blk, go, bad, n_s_pend, n_v_pend;
            int e_addr, e_data, e_rd, o_v_pend, o_v_rem, raw_src, raw_dst, len;
            s_act = (s_rem > 0) || (s_pend != 0);
            s_rd  = (s_rem > 0) && tick && (s_wait == 1);
            v_rd  = (v_rem > 0) && tick && !s_act && (v_wait == 1);
            e_we = 0; e_re = 0; e_addr = -1; e_data = -1;
            if (s_pend)       begin e_we = 1; e_addr = s_wa; e_data = s_wd; end
            else if (s_rd)    begin e_re = 1; e_addr = s_src; end
            else if (v_pend)  begin e_we = 1; e_addr = v_wa; e_data = v_wd; end
            else if (v_rd)    begin e_re = 1; e_addr = v_src; end
            chk(bus_we == e_we && bus_re == e_re, (s_pend || s_rd) ? "R3 strobes" : "R8 strobes",
                {bus_we, bus_re}, {e_we, e_re});
            if (e_we || e_re)
                chk(int'(bus_addr) == e_addr, (s_pend || s_rd) ? "R3 addr" : "R10 addr",
                    bus_addr, e_addr);
            if (e_we)
                chk(int'(bus_wdata) == e_data, "R3 R8 wdata", bus_wdata, e_data);
            e_blk = model_block(int'(cpu_addr));
            chk(cpu_block == e_blk, (cpu_addr[15:8] == 8'hFE) ? "R4" : (model_color ? "R6" : "R5"),
                cpu_block, e_blk);
            e_rd = (reg_sel <= 5) ? r[reg_sel] : 'hFF;
            chk(int'(reg_rdata) == e_rd, "R11 readback", reg_rdata, e_rd);

            // observation counters
            if (bus_we) begin
                if (wr_cnt == 0) begin first_wa = bus_addr; first_wd = bus_wdata; end
                wr_cnt++; last_wa = bus_addr;
            end
            if (bus_re) begin
                if (rd_cnt == 0) first_rd_cyc = cyc;
                if (rd_cnt == 1) second_rd_cyc = cyc;
                rd_cnt++;
            end

            // object engine update
            n_s_pend = 0;
            if (s_rd) begin
                s_wa = 'hFE00 + s_off; s_wd = memf(s_src);
                s_src = (s_src + 1) & 'hFFFF; s_off++; s_rem--; s_wait = 4; n_s_pend = 1;
            end else if (tick && s_rem > 0) s_wait--;
            if (reg_we && reg_sel == 0 && reg_wdata <= 8'hF1) begin
                s_src = reg_wdata * 256; s_page = reg_wdata; s_off = 0; s_rem = 160; s_wait = 8;
                start_cyc = cyc;
            end
            s_pend = n_s_pend;

            // video engine update
            raw_src = ((r[1] << 8) | r[2]) & 'hFFF0;
            raw_dst = (((r[3] << 8) | r[4]) & 'h1FF0) | 'h8000;
            bad = (raw_src >= 'h8000) && (raw_src < 'hA000);
            len = ((reg_wdata & 'h7F) + 1) * 16;
            go = reg_we && reg_sel == 5 && !reg_wdata[7] && !bad;
            o_v_pend = v_pend; o_v_rem = v_rem;
            n_v_pend = 0;
            if (v_rd) begin
                v_wa = v_dst; v_wd = memf(v_src);
                v_src = (v_src + 1) & 'hFFFF; v_dst = (v_dst + 1) & 'hFFFF;
                v_rem--; v_wait = 2; n_v_pend = 1;
            end else if (tick && !s_act && v_rem > 0) v_wait--;
            if (o_v_pend && o_v_rem == 0) begin
                r[1] = v_src >> 8; r[2] = v_src & 255; r[3] = v_dst >> 8; r[4] = v_dst & 255;
                r[5] = r[5] | 'h80;
            end
            if (reg_we) begin
                if (reg_sel >= 1 && reg_sel <= 4) r[reg_sel] = reg_wdata;
                if (reg_sel == 5 && (reg_wdata[7] || !bad)) r[5] = reg_wdata;
            end
            if (go) begin
                v_src = raw_src; v_dst = raw_dst; v_rem = len; v_wait = 1;
            end
            v_pend = n_v_pend;
            if (reg_we && reg_sel == 0 && reg_wdata <= 8'hF1) r[0] = reg_wdata;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr_reg(input int sel, input int val);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = 3'(sel); reg_wdata = 8'(val);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input int sel, output int val);
        @(negedge clk);
        reg_sel = 3'(sel);
        #1.5;
        val = reg_rdata;
    endtask

    task automatic clear_obs();
        wr_cnt = 0; rd_cnt = 0; first_rd_cyc = -1; second_rd_cyc = -1;
        first_wa = -1; first_wd = -1; last_wa = -1;
    endtask

    task automatic wait_idle(input int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (s_rem == 0 && s_pend == 0 && v_rem == 0 && v_pend == 0) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic probe(input int a, input bit exp, input string tag);
        @(negedge clk);
        cpu_addr = 16'(a);
        #1.5;
        chk(cpu_block == exp, tag, cpu_block, exp);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        summary();
    end

    initial begin
        int v;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        @(negedge clk); #1.5;
        chk(!bus_we && !bus_re && !cpu_block, "R1 idle", {bus_we, bus_re, cpu_block}, 0);
        rd_reg(5, v); chk(v == 'hFF, "R1 ctrl", v, 'hFF);
        rd_reg(1, v); chk(v == 0, "R1 src_hi", v, 0);
        rd_reg(0, v); chk(v == 0, "R1 page", v, 0);
        rd_reg(7, v); chk(v == 'hFF, "R11 unused code", v, 'hFF);

        // R7 R8 R9 basic video copy
        wr_reg(1, 'h12); wr_reg(2, 'h34); wr_reg(3, 'h05); wr_reg(4, 'h67);
        clear_obs();
        wr_reg(5, 'h01);
        wait_idle(2000);
        chk(wr_cnt == 32, "R8 byte count", wr_cnt, 32);
        chk(first_wa == 'h8560, "R7 dest mask", first_wa, 'h8560);
        chk(first_wd == memf('h1230), "R7 source mask", first_wd, memf('h1230));
        rd_reg(1, v); chk(v == 'h12, "R9 src_hi", v, 'h12);
        rd_reg(2, v); chk(v == 'h50, "R9 src_lo", v, 'h50);
        rd_reg(3, v); chk(v == 'h85, "R9 dst_hi", v, 'h85);
        rd_reg(4, v); chk(v == 'h80, "R9 dst_lo", v, 'h80);
        rd_reg(5, v); chk(v == 'h81, "R9 done flag", v, 'h81);

        // R2 R3 R4 R5 object copy, original model
        clear_obs();
        wr_reg(0, 'hC1);
        probe('hFE10, 1'b1, "R4 attr area");
        probe('hA000, 1'b1, "R5 idx6 A000");
        probe('hFDFF, 1'b1, "R5 idx6 FDFF");
        probe('h9FFF, 1'b0, "R5 idx6 VRAM open");
        wait_idle(2000);
        chk(first_rd_cyc - start_cyc == 8, "R3 first delay", first_rd_cyc - start_cyc, 8);
        chk(second_rd_cyc - first_rd_cyc == 4, "R3 gap", second_rd_cyc - first_rd_cyc, 4);
        chk(wr_cnt == 160, "R3 count", wr_cnt, 160);
        chk(first_wa == 'hFE00 && last_wa == 'hFE9F, "R3 dest range", last_wa, 'hFE9F);
        chk(first_wd == memf('hC100), "R2 source", first_wd, memf('hC100));
        probe('hFE10, 1'b0, "R4 idle open");

        // R6 colour model windows
        model_color = 1'b1;
        wr_reg(0, 'hC1);
        probe('hC000, 1'b1, "R6 idx6 C000");
        probe('hA000, 1'b0, "R6 idx6 A000 open");
        wait_idle(2000);
        wr_reg(0, 'h80);
        probe('h8000, 1'b1, "R6 idx4 8000");
        probe('hC000, 1'b0, "R6 idx4 C000 open");
        wait_idle(2000);
        wr_reg(0, 'h20);
        probe('hB000, 1'b1, "R6 idx1 B000");
        probe('hC000, 1'b0, "R6 idx1 C000 open");
        wait_idle(2000);
        model_color = 1'b0;
        wr_reg(0, 'h80);
        probe('h8000, 1'b1, "R5 idx4 8000");
        probe('hA000, 1'b0, "R5 idx4 A000 open");
        wait_idle(2000);

        // R2 page limit
        clear_obs();
        wr_reg(0, 'hF2);
        repeat (20) @(negedge clk);
        chk(rd_cnt == 0, "R2 high page ignored", rd_cnt, 0);
        rd_reg(0, v); chk(v == 'h80, "R2 page kept", v, 'h80);
        clear_obs();
        wr_reg(0, 'hF1);
        wait_idle(2000);
        chk(wr_cnt == 160, "R2 limit page runs", wr_cnt, 160);

        // R3 with gated ticks
        rand_tick = 1'b1;
        clear_obs();
        wr_reg(0, 'h45);
        wait_idle(5000);
        chk(wr_cnt == 160, "R3 gated count", wr_cnt, 160);
        rand_tick = 1'b0;

        // R7 rejected source, R8 bit7 set
        wr_reg(1, 'h88); wr_reg(2, 'h00);
        clear_obs();
        wr_reg(5, 'h03);
        repeat (10) @(negedge clk);
        chk(rd_cnt == 0, "R7 reject no bus", rd_cnt, 0);
        rd_reg(5, v); chk(v == 'h81, "R7 reject ctrl kept", v, 'h81);
        wr_reg(1, 'h40);
        clear_obs();
        wr_reg(5, 'h85);
        repeat (10) @(negedge clk);
        chk(rd_cnt == 0, "R8 bit7 no start", rd_cnt, 0);
        rd_reg(5, v); chk(v == 'h85, "R8 bit7 stored", v, 'h85);

        // R10 priority with gated ticks
        rand_tick = 1'b1;
        wr_reg(1, 'h30); wr_reg(2, 'h07); wr_reg(3, 'hFF); wr_reg(4, 'hFF);
        clear_obs();
        wr_reg(5, 'h0F);
        repeat (20) @(negedge clk);
        wr_reg(0, 'hD0);
        wait_idle(8000);
        rand_tick = 1'b0;
        chk(wr_cnt == 256 + 160, "R10 total bytes", wr_cnt, 416);
        rd_reg(2, v); chk(v == 'h00, "R10 resume src_lo", v, 'h00);
        rd_reg(1, v); chk(v == 'h31, "R10 resume src_hi", v, 'h31);
        rd_reg(3, v); chk(v == 'hA0, "R10 dst wrap", v, 'hA0);

        // R8 largest length
        wr_reg(1, 'h00); wr_reg(2, 'h00); wr_reg(3, 'h00); wr_reg(4, 'h00);
        clear_obs();
        wr_reg(5, 'h7F);
        wait_idle(6000);
        chk(wr_cnt == 2048, "R8 max length", wr_cnt, 2048);
        rd_reg(1, v); chk(v == 'h08, "R9 max src_hi", v, 'h08);
        rd_reg(5, v); chk(v == 'hFF, "R9 max ctrl", v, 'hFF);

        summary();
    end

endmodule